// File: doc/BRIEF.md
# Serial display write engine with data/command line

This block sends bytes from a host to a display controller over a four-wire serial link. A byte and a one-bit flag arrive together through a valid/ready handshake. For each byte the block pulls chip select low, drives the flag onto a separate data/command line, and clocks out the eight bits most significant first. It then keeps chip select low for a hold window before it takes the next byte.

The serial clock is built from the system clock. Its high time, its low time, the chip select setup before the first rising edge, and the chip select hold after the last falling edge are each a whole number of system clock cycles, set by parameters. The clock rests low. Data changes on the falling edge and is sampled by the controller on the rising edge, which is mode 0.

If the next byte is offered in the cycle in which ready comes back, chip select stays low. The next burst then starts one low time later. If no byte is waiting in that cycle, chip select goes high.

Top module: `spi_dc_tx`

## Requirements
- R1: After reset, cs_n is 1, sclk is 0 and in_ready is 1.
- R2: A byte is taken on a clock edge where in_valid and in_ready are both 1. in_ready is 0 from the next cycle until the hold window of that byte ends. No clock burst occurs without a byte having been taken.
- R3: Each byte is sent as exactly BITS sclk pulses. Each pulse is high for HI_CYC cycles. Consecutive rising edges within a byte are HI_CYC+LO_CYC cycles apart.
- R4: The bits leave MSB first: at the k-th rising edge of a byte, mosi equals bit BITS-k of the byte. mosi does not change while sclk is high.
- R5: dc equals the in_dc flag taken with the byte (1 = data, 0 = command) at every rising edge of that byte. dc changes only when a byte is taken.
- R6: When cs_n falls, the first rising edge of sclk comes exactly CSS_CYC cycles later, and cs_n stays 0 throughout the burst.
- R7: in_ready returns to 1 exactly CSH_CYC cycles after the last falling edge of a byte, and cs_n is still 0 at that point.
- R8: A byte offered in the cycle in which in_ready returns with cs_n 0 keeps cs_n at 0. Its first rising edge comes LO_CYC+1 cycles after that cycle.
- R9: If in_valid is 0 in the cycle in which in_ready returns with cs_n 0, cs_n is 1 in the next cycle.
- R10: sclk is 0 whenever cs_n is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A byte is offered |
| in_ready | output | 1 | The block can take a byte this cycle |
| in_byte | input | BITS | Byte to send |
| in_dc | input | 1 | 1 = display data, 0 = command |
| cs_n | output | 1 | Chip select, active low |
| sclk | output | 1 | Serial clock, rests low |
| mosi | output | 1 | Serial data, MSB first |
| dc | output | 1 | Data/command line for the current byte |

## Verification
The hardest case to reach is the chained transfer. The next byte has to be present in the single cycle in which ready returns while chip select is still low. Missing that cycle by one edge makes chip select rise and start a fresh setup window. The stimulus covers this by holding valid high with the next byte straight after each handshake. It also mixes zero gaps with gaps that are longer than a whole byte. The monitor checks the spacing of the first clock edge against whichever of the two starts the handshake produced.

// File: rtl/spi_dc_pkg.sv
package spi_dc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,   // chip select high, ready
    ST_SETUP,  // chip select low, waiting before first rising edge
    ST_HIGH,   // serial clock high
    ST_LOW,    // serial clock low between pulses
    ST_HOLD,   // chip select hold after last falling edge
    ST_DONE,   // one cycle ready with chip select still low
    ST_LEAD    // data setup before first edge of a chained byte
  } tx_state_t;

  function automatic int max4(int a, int b, int c, int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

  // number of cycles spent in a timed state; untimed states last one cycle
  function automatic int phase_cycles(tx_state_t s, int hi, int lo, int css, int csh);
    case (s)
      ST_SETUP: return css;
      ST_HIGH:  return hi;
      ST_LOW:   return lo;
      ST_LEAD:  return lo;
      ST_HOLD:  return csh;
      default:  return 1;
    endcase
  endfunction

endpackage

// File: rtl/spi_dc_timer.sv
module spi_dc_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt <= '0;
    else if (load)
      cnt <= load_val;
    else if (cnt != '0)
      cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/spi_dc_shifter.sv
module spi_dc_shifter #(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [BITS-1:0] data,
  input  logic            shift,
  output logic            msb,
  output logic            last
);
  localparam int IDX_W = (BITS < 2) ? 1 : $clog2(BITS);

  logic [BITS-1:0]  sr;
  logic [IDX_W-1:0] idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr  <= '0;
      idx <= '0;
    end else if (load) begin
      sr  <= data;
      idx <= '0;
    end else if (shift) begin
      sr  <= sr << 1;
      idx <= idx + 1'b1;
    end
  end

  assign msb  = sr[BITS-1];
  assign last = (idx == IDX_W'(BITS - 1));
endmodule

// File: rtl/spi_dc_tx.sv
module spi_dc_tx
  import spi_dc_pkg::*;
#(
  parameter int HI_CYC  = 5,
  parameter int LO_CYC  = 5,
  parameter int CSS_CYC = 3,
  parameter int CSH_CYC = 2,
  parameter int BITS    = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [BITS-1:0] in_byte,
  input  logic            in_dc,
  output logic            cs_n,
  output logic            sclk,
  output logic            mosi,
  output logic            dc
);
  localparam int MAXC  = max4(HI_CYC, LO_CYC, CSS_CYC, CSH_CYC);
  localparam int CNT_W = (MAXC < 2) ? 1 : $clog2(MAXC);

  tx_state_t        st, nxt;
  logic             phase_done;
  logic             accept;
  logic             bit_fall;   // leaving a high phase with bits left
  logic             burst_end;  // leaving the last high phase
  logic             last_bit;
  logic             shift_msb;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             dc_q;

  assign in_ready = (st == ST_IDLE) || (st == ST_DONE);
  assign accept   = in_ready && in_valid;

  always_comb begin
    nxt = st;
    case (st)
      ST_IDLE:  if (in_valid) nxt = ST_SETUP;
      ST_SETUP: if (phase_done) nxt = ST_HIGH;
      ST_HIGH:  if (phase_done) nxt = last_bit ? ST_HOLD : ST_LOW;
      ST_LOW:   if (phase_done) nxt = ST_HIGH;
      ST_HOLD:  if (phase_done) nxt = ST_DONE;
      ST_DONE:  nxt = in_valid ? ST_LEAD : ST_IDLE;
      ST_LEAD:  if (phase_done) nxt = ST_HIGH;
      default:  nxt = ST_IDLE;
    endcase
  end

  assign bit_fall  = (st == ST_HIGH) && phase_done && !last_bit;
  assign burst_end = (st == ST_HIGH) && phase_done && last_bit;
  assign tmr_load  = (nxt != st);
  assign tmr_val   = CNT_W'(phase_cycles(nxt, HI_CYC, LO_CYC, CSS_CYC, CSH_CYC) - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      dc_q <= 1'b0;
    end else begin
      st <= nxt;
      if (accept) dc_q <= in_dc;
    end
  end

  spi_dc_timer #(.CNT_W(CNT_W)) i_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (phase_done)
  );

  spi_dc_shifter #(.BITS(BITS)) i_shift (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (accept),
    .data  (in_byte),
    .shift (bit_fall),
    .msb   (shift_msb),
    .last  (last_bit)
  );

  assign cs_n = (st == ST_IDLE);
  assign sclk = (st == ST_HIGH);
  assign mosi = shift_msb;
  assign dc   = dc_q;
endmodule

// File: rtl/spi_dc_tx_chk.sv
module spi_dc_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic cs_n,
  input logic sclk,
  input logic mosi,
  input logic dc
);
  // R10
  idle_clock_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);

  // R4
  mosi_steady_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> (mosi == $past(mosi)));

  // R5
  dc_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> $stable(dc));

  // R2
  busy_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  // R8
  chain_keeps_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !cs_n && in_valid) |=> !cs_n);

  // R9
  release_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !cs_n && !in_valid) |=> cs_n);
endmodule

bind spi_dc_tx spi_dc_tx_chk i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .cs_n     (cs_n),
  .sclk     (sclk),
  .mosi     (mosi),
  .dc       (dc)
);

// File: tb/test_spi_dc_tx.sv
module test_spi_dc_tx;
  localparam int CLK_PERIOD = 10;
  localparam int HI  = 5;
  localparam int LO  = 5;
  localparam int CSS = 3;
  localparam int CSH = 2;
  localparam int WATCHDOG = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_byte = 8'h00;
  logic       in_dc = 1'b0;
  logic       cs_n, sclk, mosi, dc;

  int nchk = 0;
  int nerr = 0;
  int cyc = 0;

  spi_dc_tx #(.HI_CYC(HI), .LO_CYC(LO), .CSS_CYC(CSS), .CSH_CYC(CSH), .BITS(8)) i_spi_dc_tx (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_byte(in_byte), .in_dc(in_dc), .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .dc(dc)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // bench view of timing: spacing of first edge from the start of a byte
  function automatic int first_edge_gap(bit chained);
    return chained ? LO + 1 : CSS;
  endfunction

  // shared between driver and monitor
  logic [8:0] expq[$];
  bit  acc_b2b = 1'b0;
  int  acc_cyc = 0;
  bit  mon_en = 1'b0;
  int  cs_rises = 0;
  int  bytes_done = 0;

  // monitor
  bit   pcs = 1'b1, psclk = 1'b0, pmosi = 1'b0, prdy = 1'b1;
  int   t_csf = 0, t_rise = 0, t_fall = 0, nb = 0;
  bit   wait_rdy = 1'b0;
  logic [8:0] cur = '0;
  logic [7:0] got = '0;

  always @(negedge clk) begin
    if (mon_en) begin
      if (cs_n) chk(!sclk, "R10 clock low while deselected", sclk, 0);
      if (pcs && !cs_n) t_csf = cyc;
      if (!pcs && cs_n) cs_rises++;
      if (sclk && psclk) chk(mosi == pmosi, "R4 mosi steady while high", mosi, pmosi);
      if (nb != 0) chk(!cs_n, "R6 select low in burst", cs_n, 0);
      if (sclk && !psclk) begin
        if (nb == 0) begin
          if (expq.size() == 0) begin
            chk(1'b0, "R2 burst without a taken byte", 1, 0);
            cur = '0;
          end else begin
            cur = expq.pop_front();
          end
          if (acc_b2b)
            chk(cyc - acc_cyc == first_edge_gap(1'b1), "R8 chained first edge", cyc - acc_cyc, LO + 1);
          else
            chk(cyc - t_csf == first_edge_gap(1'b0), "R6 select setup", cyc - t_csf, CSS);
        end else begin
          chk(cyc - t_rise == HI + LO, "R3 pulse period", cyc - t_rise, HI + LO);
        end
        chk(dc == cur[8], "R5 dc at edge", dc, cur[8]);
        got = {got[6:0], mosi};
        nb++;
        t_rise = cyc;
      end
      if (!sclk && psclk) begin
        chk(cyc - t_rise == HI, "R3 high time", cyc - t_rise, HI);
        if (nb == 8) begin
          chk(got == cur[7:0], "R4 byte MSB first", got, cur[7:0]);
          nb = 0;
          t_fall = cyc;
          wait_rdy = 1'b1;
          bytes_done++;
        end
      end
      if (wait_rdy && in_ready && !prdy) begin
        chk(cyc - t_fall == CSH, "R7 hold before ready", cyc - t_fall, CSH);
        chk(!cs_n, "R7 select low at ready", cs_n, 0);
        wait_rdy = 1'b0;
      end
    end
    pcs = cs_n; psclk = sclk; pmosi = mosi; prdy = in_ready;
  end

  // must be called at a falling clock edge; returns at the falling edge after the handshake
  task automatic offer(input logic [7:0] b, input logic d);
    in_byte = b;
    in_dc = d;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    acc_b2b = !cs_n;
    acc_cyc = cyc;
    expq.push_back({d, b});
    @(negedge clk);
    chk(!in_ready, "R2 busy after take", in_ready, 0);
  endtask

  task automatic drain();
    in_valid = 1'b0;
    while (!(in_ready && cs_n && !wait_rdy && expq.size() == 0)) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    fork
      begin
        void'($urandom(32'h5EED_0001));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk(cs_n == 1'b1, "R1 reset cs_n", cs_n, 1);
        chk(sclk == 1'b0, "R1 reset sclk", sclk, 0);
        chk(in_ready == 1'b1, "R1 reset ready", in_ready, 1);
        mon_en = 1'b1;

        // directed single bytes, command then data
        offer(8'h80, 1'b0); drain();
        offer(8'h01, 1'b1); drain();
        offer(8'hFF, 1'b0); drain();
        offer(8'h00, 1'b1); drain();

        // R9: no byte waiting when ready returns
        offer(8'hA5, 1'b1);
        in_valid = 1'b0;
        while (!(in_ready && !cs_n)) @(negedge clk);
        @(negedge clk);
        chk(cs_n == 1'b1, "R9 select released", cs_n, 1);
        drain();

        // R8: chained bytes keep select low
        begin
          int r0;
          r0 = cs_rises;
          offer(8'hAE, 1'b0);
          offer(8'h3F, 1'b0);
          offer(8'h5A, 1'b1);
          offer(8'hC3, 1'b1);
          drain();
          chk(cs_rises - r0 == 1, "R8 one select release for a chain", cs_rises - r0, 1);
        end

        // random traffic with zero and long gaps
        for (int i = 0; i < 200; i++) begin
          offer(8'($urandom_range(0, 255)), 1'($urandom_range(0, 1)));
          if ($urandom_range(0, 9) < 6) begin
            in_valid = 1'b0;
            repeat ($urandom_range(1, 120)) @(negedge clk);
          end
        end
        drain();
        chk(expq.size() == 0, "R4 all taken bytes sent", expq.size(), 0);
        chk(bytes_done == 209, "R3 burst count", bytes_done, 209);
      end
      begin
        repeat (WATCHDOG) @(posedge clk);
        chk(1'b0, "watchdog expired", cyc, WATCHDOG);
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule